// File: doc/BRIEF.md
# Write-Through Store Queue with Read Bypass

This block sits between a write-through data cache and a slow main memory. Each processor store updates the cache and, in the same cycle, is pushed into a small first-in first-out queue. The queue then retires its stores to memory on its own, oldest first, through one memory request port with a valid/ready handshake. The processor stalls only when the queue is full.

A read miss does not have to wait for the whole queue to drain. The block checks the read's word address and byte mask against every queued store. If no queued store touches the bytes being read, the read goes to memory next, ahead of all pending stores. If some stores do overlap, the block drains stores up to and including the youngest overlapping one and then issues the read. Stores queued after that one stay behind the read.

The arbiter is a four-state machine:
- IDLE: the memory port is quiet.
- WRITE: the oldest store is presented to memory.
- READ: the read miss is presented to memory.
- FLUSH: stores are drained ahead of a read that has a hazard.

The transitions are:
- IDLE to READ when a read has no hazard.
- IDLE to FLUSH when a read has a hazard.
- IDLE to WRITE when no read is waiting and the queue is not empty.
- WRITE to IDLE, and READ to IDLE, when memory accepts.
- FLUSH to READ when memory accepts the last store that must drain.

Top module: `wt_store_queue`

## Requirements
- R1: After reset, `st_ready` is 1, and both `mem_valid` and `rd_grant` are 0.
- R2: A store is accepted when `st_valid` and `st_ready` are both 1. `st_ready` is 0 exactly while DEPTH stores (default 4) are held.
- R3: If a store is accepted in the same cycle that memory accepts a queued store, the occupancy does not change.
- R4: Queued stores go to memory one at a time, oldest first. Each one is presented with `mem_write`=1 and carries the address, data and byte mask it was accepted with.
- R5: Once `mem_valid` is 1, `mem_valid`, `mem_write`, `mem_addr`, `mem_data` and `mem_be` all hold unchanged until `mem_ready` is 1.
- R6: A read is presented with `mem_write`=0, `mem_addr`=`rd_addr` and `mem_be`=`rd_be`. When it overlaps no queued store, it is the next memory operation after the one in flight, ahead of all pending stores.
- R7: A read overlaps a queued store only if the word addresses are equal and the two byte masks share at least one set bit. An equal address with disjoint masks does not overlap.
- R8: When a read overlaps queued stores, the block presents stores up to and including the youngest overlapping one. It then presents the read, before any younger store.
- R9: `rd_grant` is 1 in exactly the cycle in which memory accepts the read. A store already being presented completes before the read is presented. `rd_valid` and the read fields must be held until the grant.
- R10: With an empty queue and no read waiting, `mem_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Queue can accept a store |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte mask |
| rd_valid | input | 1 | Read miss request, held until granted |
| rd_addr | input | ADDR_W | Read word address |
| rd_be | input | DATA_W/8 | Read byte mask |
| rd_grant | output | 1 | Read accepted by memory this cycle |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | 1 for a store, 0 for a read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_data | output | DATA_W | Store data (0 for reads) |
| mem_be | output | DATA_W/8 | Byte mask |

## Verification
Errors in the head or tail pointer show up in the memory transaction log at the first accepted store. They appear as a wrong address or wrong data, or as stores leaving out of order. An occupancy counter that is off by one shows up as `st_ready` dropping one store early or late. A wrong hazard count in the arbiter shows up at the read's position in the log. Too small a count lets the read overtake an overlapping store; too large a count drains a younger store ahead of the read. Both become visible within a few cycles of `mem_ready` rising.

// File: rtl/wtb_pkg.sv
package wtb_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_WRITE = 2'd1,
        ARB_READ  = 2'd2,
        ARB_FLUSH = 2'd3
    } arb_state_e;
endpackage

// File: rtl/wtb_queue.sv
module wtb_queue #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [ADDR_W-1:0]             push_addr,
    input  logic [DATA_W-1:0]             push_data,
    input  logic [BE_W-1:0]               push_be,
    input  logic                          pop,
    output logic [ADDR_W-1:0]             head_addr,
    output logic [DATA_W-1:0]             head_data,
    output logic [BE_W-1:0]               head_be,
    output logic                          full,
    output logic                          empty,
    output logic [PTR_W-1:0]              head_ptr,
    output logic [CNT_W-1:0]              count,
    output logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
    output logic [DEPTH-1:0][BE_W-1:0]    slot_be
);
    logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
    logic [DEPTH-1:0][DATA_W-1:0] data_q;
    logic [DEPTH-1:0][BE_W-1:0]   be_q;
    logic [PTR_W-1:0]             tail_ptr;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            count    <= '0;
        end else begin
            if (push) tail_ptr <= wrap_inc(tail_ptr);
            if (pop)  head_ptr <= wrap_inc(head_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[tail_ptr] <= push_addr;
            data_q[tail_ptr] <= push_data;
            be_q[tail_ptr]   <= push_be;
        end
    end

    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);
    assign head_addr = addr_q[head_ptr];
    assign head_data = data_q[head_ptr];
    assign head_be   = be_q[head_ptr];
    assign slot_addr = addr_q;
    assign slot_be   = be_q;

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(count));
    assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/wtb_hazard.sv
module wtb_hazard #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int BE_W   = 4,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    input  logic [DEPTH-1:0][BE_W-1:0]   slot_be,
    input  logic [PTR_W-1:0]             head_ptr,
    input  logic [CNT_W-1:0]             count,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [BE_W-1:0]              rd_be,
    output logic                         hit,
    output logic [CNT_W-1:0]             need
);
    localparam int SUM_W = PTR_W + 1;

    always_comb begin
        need = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [SUM_W-1:0] sum;
            logic [PTR_W-1:0] idx;
            sum = {1'b0, head_ptr} + SUM_W'(k);
            if (sum >= SUM_W'(DEPTH)) sum = sum - SUM_W'(DEPTH);
            idx = sum[PTR_W-1:0];
            if ((CNT_W'(k) < count) && (slot_addr[idx] == rd_addr)
                && ((slot_be[idx] & rd_be) != '0))
                need = CNT_W'(k + 1);
        end
        hit = (need != '0);
    end
endmodule

// File: rtl/wtb_arbiter.sv
module wtb_arbiter
    import wtb_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_valid,
    input  logic             hit,
    input  logic [CNT_W-1:0] need,
    input  logic             q_empty,
    input  logic             mem_ready,
    output logic             mem_valid,
    output logic             mem_write,
    output logic             pop,
    output logic             rd_grant
);
    arb_state_e       state, state_nx;
    logic [CNT_W-1:0] drain_left, drain_nx;

    always_comb begin
        state_nx = state;
        drain_nx = drain_left;
        unique case (state)
            ARB_IDLE: begin
                if (rd_valid && !hit) begin
                    state_nx = ARB_READ;
                end else if (rd_valid && hit) begin
                    state_nx = ARB_FLUSH;
                    drain_nx = need;
                end else if (!q_empty) begin
                    state_nx = ARB_WRITE;
                end
            end
            ARB_WRITE: if (mem_ready) state_nx = ARB_IDLE;
            ARB_READ:  if (mem_ready) state_nx = ARB_IDLE;
            ARB_FLUSH: begin
                if (mem_ready) begin
                    drain_nx = drain_left - 1'b1;
                    if (drain_left == CNT_W'(1)) state_nx = ARB_READ;
                end
            end
            default: state_nx = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ARB_IDLE;
            drain_left <= '0;
        end else begin
            state      <= state_nx;
            drain_left <= drain_nx;
        end
    end

    always_comb begin
        mem_valid = 1'b0;
        mem_write = 1'b0;
        unique case (state)
            ARB_IDLE:  ;
            ARB_WRITE: begin mem_valid = 1'b1; mem_write = 1'b1; end
            ARB_FLUSH: begin mem_valid = 1'b1; mem_write = 1'b1; end
            ARB_READ:  mem_valid = 1'b1;
            default:   ;
        endcase
        pop      = mem_write && mem_ready;
        rd_grant = (state == ARB_READ) && mem_ready;
    end

    assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE && rd_valid && !hit) |=> (mem_valid && !mem_write));
    assert_hazard_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE && rd_valid && hit) |=> (mem_valid && mem_write));
    assert_flush_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_FLUSH) |-> (drain_left != '0));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE && !rd_valid && q_empty) |=> !mem_valid);
endmodule

// File: rtl/wt_store_queue.sv
module wt_store_queue #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [ADDR_W-1:0]     st_addr,
    input  logic [DATA_W-1:0]     st_data,
    input  logic [DATA_W/8-1:0]   st_be,
    input  logic                  rd_valid,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [DATA_W/8-1:0]   rd_be,
    output logic                  rd_grant,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic                  mem_write,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_data,
    output logic [DATA_W/8-1:0]   mem_be
);
    localparam int BE_W  = DATA_W / 8;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic                         push, pop, q_full, q_empty, hit;
    logic [ADDR_W-1:0]            head_addr;
    logic [DATA_W-1:0]            head_data;
    logic [BE_W-1:0]              head_be;
    logic [PTR_W-1:0]             head_ptr;
    logic [CNT_W-1:0]             count, need;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][BE_W-1:0]   slot_be;

    assign st_ready = !q_full;
    assign push     = st_valid && st_ready;

    wtb_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W),
                .PTR_W(PTR_W), .CNT_W(CNT_W)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(push), .push_addr(st_addr),
        .push_data(st_data), .push_be(st_be), .pop(pop),
        .head_addr(head_addr), .head_data(head_data), .head_be(head_be),
        .full(q_full), .empty(q_empty), .head_ptr(head_ptr), .count(count),
        .slot_addr(slot_addr), .slot_be(slot_be));

    wtb_hazard #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BE_W(BE_W),
                 .PTR_W(PTR_W), .CNT_W(CNT_W)) u_hazard (
        .slot_addr(slot_addr), .slot_be(slot_be), .head_ptr(head_ptr),
        .count(count), .rd_addr(rd_addr), .rd_be(rd_be),
        .hit(hit), .need(need));

    wtb_arbiter #(.CNT_W(CNT_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .hit(hit), .need(need),
        .q_empty(q_empty), .mem_ready(mem_ready), .mem_valid(mem_valid),
        .mem_write(mem_write), .pop(pop), .rd_grant(rd_grant));

    assign mem_addr = mem_write ? head_addr : rd_addr;
    assign mem_data = mem_write ? head_data : '0;
    assign mem_be   = mem_write ? head_be   : rd_be;

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write)
            && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));
    assert_grant_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |-> (rd_valid && !mem_write));
endmodule

// File: tb/tb_wt_store_queue.sv
module tb_wt_store_queue;
    localparam int CLK_P  = 10;
    localparam int AW     = 16;
    localparam int DW     = 32;
    localparam int BW     = DW / 8;
    localparam int DEPTH  = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic st_valid = 1'b0, rd_valid = 1'b0, mem_ready = 1'b0;
    logic [AW-1:0] st_addr = '0, rd_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [BW-1:0] st_be = '0, rd_be = '0;
    logic st_ready, rd_grant, mem_valid, mem_write;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic [BW-1:0] mem_be;

    int n_chk = 0, n_bad = 0, log_n = 0;
    bit grant_seen = 0, done = 0;
    logic          log_wr   [32];
    logic [AW-1:0] log_addr [32];
    logic [DW-1:0] log_data [32];

    wt_store_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_be(rd_be),
        .rd_grant(rd_grant), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_be(mem_be));

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory-side log, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready && log_n < 32) begin
            log_wr[log_n]   = mem_write;
            log_addr[log_n] = mem_addr;
            log_data[log_n] = mem_data;
            log_n++;
            if (!mem_write) begin
                chk("R9 grant with read accept", rd_grant, 1'b1);
                chk("R6 read mask", mem_be, rd_be);
                grant_seen = 1;
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
        if (grant_seen) begin rd_valid = 0; grant_seen = 0; end
    endtask

    task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] b);
        st_valid = 1; st_addr = a; st_data = d; st_be = b;
        step();
        st_valid = 0;
    endtask

    task automatic drain();
        mem_ready = 1;
        repeat (20) step();
        mem_ready = 0;
    endtask

    task automatic chk_log(input string req, input int i, input logic wr,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
        chk({req, " kind"}, log_wr[i], wr);
        chk({req, " addr"}, log_addr[i], a);
        if (wr) chk({req, " data"}, log_data[i], d);
    endtask

    task automatic t_reset();
        chk("R1 st_ready", st_ready, 1'b1);
        chk("R1 mem_valid", mem_valid, 1'b0);
        chk("R1 rd_grant", rd_grant, 1'b0);
        repeat (3) step();
        chk("R10 idle quiet", mem_valid, 1'b0);
    endtask

    task automatic t_fill_drain();
        log_n = 0;
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 ready before full", st_ready, 1'b1);
            push(AW'(16'h100 + i), DW'(32'hA000 + i), 4'hF);
        end
        chk("R2 stall when full", st_ready, 1'b0);
        for (int i = 0; i < 3; i++) begin
            chk("R5 held valid", mem_valid, 1'b1);
            chk("R5 held addr", mem_addr, 16'h100);
            chk("R5 held data", mem_data, 32'hA000);
            step();
        end
        drain();
        chk("R4 count", log_n, DEPTH);
        for (int i = 0; i < DEPTH; i++)
            chk_log("R4 order", i, 1'b1, AW'(16'h100 + i), DW'(32'hA000 + i));
        chk("R10 quiet after drain", mem_valid, 1'b0);
        chk("R2 ready after drain", st_ready, 1'b1);
    endtask

    task automatic t_bypass();
        log_n = 0;
        push(16'h200, 32'hB0, 4'hF);
        push(16'h201, 32'hB1, 4'hF);
        push(16'h202, 32'hB2, 4'hF);
        rd_valid = 1; rd_addr = 16'h300; rd_be = 4'hF;
        step(); step();
        chk("R9 write in flight kept", mem_write, 1'b1);
        chk("R9 no early grant", rd_grant, 1'b0);
        drain();
        chk("R6 count", log_n, 4);
        chk_log("R9 inflight first", 0, 1'b1, 16'h200, 32'hB0);
        chk_log("R6 read bypass", 1, 1'b0, 16'h300, '0);
        chk_log("R6 later write", 2, 1'b1, 16'h201, 32'hB1);
        chk_log("R6 later write", 3, 1'b1, 16'h202, 32'hB2);
    endtask

    task automatic t_hazard_mid();
        log_n = 0;
        push(16'h400, 32'hC0, 4'hF);
        push(16'h410, 32'hC1, 4'h3);
        push(16'h420, 32'hC2, 4'hF);
        rd_valid = 1; rd_addr = 16'h410; rd_be = 4'h1;
        step();
        drain();
        chk("R8 count", log_n, 4);
        chk_log("R8 oldest", 0, 1'b1, 16'h400, 32'hC0);
        chk_log("R8 matching", 1, 1'b1, 16'h410, 32'hC1);
        chk_log("R8 read next", 2, 1'b0, 16'h410, '0);
        chk_log("R8 younger after", 3, 1'b1, 16'h420, 32'hC2);
    endtask

    task automatic t_hazard_youngest();
        log_n = 0;
        push(16'h500, 32'hD0, 4'hF);
        push(16'h510, 32'hD1, 4'h8);
        push(16'h510, 32'hD2, 4'hC);
        push(16'h520, 32'hD3, 4'hF);
        rd_valid = 1; rd_addr = 16'h510; rd_be = 4'h4;
        step();
        drain();
        chk("R8 count youngest", log_n, 5);
        chk_log("R8 drain 0", 0, 1'b1, 16'h500, 32'hD0);
        chk_log("R8 drain 1", 1, 1'b1, 16'h510, 32'hD1);
        chk_log("R8 drain youngest match", 2, 1'b1, 16'h510, 32'hD2);
        chk_log("R8 read", 3, 1'b0, 16'h510, '0);
        chk_log("R8 last", 4, 1'b1, 16'h520, 32'hD3);
    endtask

    task automatic t_disjoint();
        log_n = 0;
        push(16'h600, 32'hE0, 4'hF);
        push(16'h610, 32'hE1, 4'h3);
        rd_valid = 1; rd_addr = 16'h610; rd_be = 4'hC;
        step();
        drain();
        chk("R7 count", log_n, 3);
        chk_log("R7 inflight", 0, 1'b1, 16'h600, 32'hE0);
        chk_log("R7 disjoint bytes bypass", 1, 1'b0, 16'h610, '0);
        chk_log("R7 store after", 2, 1'b1, 16'h610, 32'hE1);
    endtask

    task automatic t_simul();
        log_n = 0;
        push(16'h700, 32'hF0, 4'hF);
        push(16'h701, 32'hF1, 4'hF);
        push(16'h702, 32'hF2, 4'hF);
        st_valid = 1; st_addr = 16'h703; st_data = 32'hF3; st_be = 4'hF;
        mem_ready = 1;
        step();
        st_valid = 0; mem_ready = 0;
        chk("R3 count held", st_ready, 1'b1);
        push(16'h704, 32'hF4, 4'hF);
        chk("R2 full after fifth", st_ready, 1'b0);
        drain();
        chk("R3 count", log_n, 5);
        for (int i = 0; i < 5; i++)
            chk_log("R3 order", i, 1'b1, AW'(16'h700 + i), DW'(32'hF0 + i));
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1;
        step();
        t_reset();
        t_fill_drain();
        t_bypass();
        t_hazard_mid();
        t_hazard_youngest();
        t_disjoint();
        t_simul();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule